// File: doc/BRIEF.md
# Strobed Handshake Port Unit

This block runs the handshake for one byte-wide parallel port. One control line says which way the port points. When the port takes input, a peripheral puts a byte on its data lines and pulses an active-low strobe. The unit captures the byte and raises a buffer-full flag, which tells the peripheral to hold off until the processor has read the byte. When the port gives output, a processor write puts a byte on the port and raises buffer-full. The peripheral answers with an active-low acknowledge on the same strobe line, and that answer releases the buffer.

In both directions the unit can raise an interrupt request. It does so when the strobe or acknowledge line goes back high, but only if the interrupt-enable input is 1. Software can either poll the buffer-full flag or service the interrupt.

The strobe line is asynchronous. It passes through a synchronizer of configurable depth before its edges are detected. A chip places two copies of this unit, one per port, and feeds each copy its enable bit from a shared command register.

Top module: `hsp_port_unit`

## Requirements
- R1: After reset, buf_full, intr, per_dout and cpu_rdata are all 0.
- R2: Input mode (dir_out = 0). When the strobe falls and buf_full is 0, the byte on per_din is captured and cpu_rdata shows it. buf_full goes to 1.
- R3: Input mode. A strobe that falls while buf_full is 1 is ignored. cpu_rdata keeps the byte held earlier, and when that strobe rises it raises no interrupt.
- R4: Input mode. A one-cycle cpu_rd pulse clears both buf_full and intr.
- R5: intr goes to 1 when an accepted strobe or acknowledge rises, but only if int_en is 1 at that moment. If int_en is 0, intr stays 0.
- R6: Output mode (dir_out = 1). A cpu_wr pulse places cpu_wdata on per_dout and sets buf_full.
- R7: Output mode. An acknowledge (stb_n low) that arrives while buf_full is 1 clears buf_full. When it goes back high, intr is raised if int_en is 1.
- R8: Output mode. A cpu_wr pulse clears intr.
- R9: While the strobe is held low, intr stays 0. The request only appears after the strobe returns high.
- R10: The pulses that belong to the other direction have no effect. cpu_rd in output mode leaves buf_full unchanged, and cpu_wr in input mode leaves per_dout unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dir_out | input | 1 | Port direction: 1 = output, 0 = input |
| int_en | input | 1 | Interrupt enable bit from the command register |
| cpu_wr | input | 1 | One-cycle processor write pulse |
| cpu_wdata | input | DATA_W | Processor write data |
| cpu_rd | input | 1 | One-cycle processor read pulse |
| cpu_rdata | output | DATA_W | Byte captured from the peripheral |
| per_din | input | DATA_W | Peripheral data into the port |
| per_dout | output | DATA_W | Port data out to the peripheral |
| stb_n | input | 1 | Asynchronous active-low strobe or acknowledge |
| buf_full | output | 1 | Buffer-full handshake line |
| intr | output | 1 | Interrupt request |

## Verification
The bench sends a second strobe while the buffer is still full. A design that overwrote the held byte, or raised an interrupt for that strobe, would be caught there. The bench also samples intr while the strobe is held low. A unit that triggered on the falling edge would show the request too early. In output mode the bench checks that an acknowledge releases the buffer and that the next write clears the request. It also checks that a read in output mode, or a write in input mode, changes nothing; a unit that decoded either pulse without regard to direction would fail those checks.

// File: rtl/hsp_pkg.sv
package hsp_pkg;
   // idle level of the active-low strobe line
   localparam logic STB_IDLE = 1'b1;

   typedef enum logic {
      DIR_IN  = 1'b0,
      DIR_OUT = 1'b1
   } hsp_dir_e;

   typedef struct packed {
      logic fall;
      logic rise;
   } hsp_edge_t;
endpackage

// File: rtl/hsp_sync.sv
module hsp_sync #(
   parameter int   STAGES    = 2,
   parameter logic RESET_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_async,
   output logic q_sync
);
   initial begin
      if (STAGES < 2) $error("hsp_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   genvar gi;
   generate
      for (gi = 0; gi < STAGES; gi++) begin : g_stage
         if (gi == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[0] <= RESET_VAL;
               else        chain[0] <= d_async;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[gi] <= RESET_VAL;
               else        chain[gi] <= chain[gi-1];
            end
         end
      end
   endgenerate

   assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/hsp_edge.sv
module hsp_edge
   import hsp_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      lvl,
   output hsp_edge_t edges
);
   logic prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= STB_IDLE;
      else        prev <= lvl;
   end

   always_comb begin
      edges.fall = prev & ~lvl;
      edges.rise = ~prev & lvl;
   end
endmodule

// File: rtl/hsp_datareg.sv
module hsp_datareg #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [DATA_W-1:0] d,
   output logic [DATA_W-1:0] q
);
   initial begin
      if (DATA_W < 1) $error("hsp_datareg: DATA_W must be positive");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q <= '0;
      else if (load) q <= d;
   end
endmodule

// File: rtl/hsp_ctrl.sv
module hsp_ctrl
   import hsp_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  hsp_dir_e  dir,
   input  logic      int_en,
   input  logic      cpu_wr,
   input  logic      cpu_rd,
   input  hsp_edge_t edges,
   output logic      load_in,
   output logic      load_out,
   output logic      buf_full,
   output logic      intr
);
   logic accepted;
   logic ack_ok;
   logic bf_nxt, acc_nxt, intr_nxt;

   always_comb begin
      load_in  = (dir == DIR_IN)  && edges.fall && !buf_full;
      ack_ok   = (dir == DIR_OUT) && edges.fall && buf_full;
      load_out = (dir == DIR_OUT) && cpu_wr;

      bf_nxt = buf_full;
      if (dir == DIR_IN) begin
         if (cpu_rd)  bf_nxt = 1'b0;
         if (load_in) bf_nxt = 1'b1;
      end else begin
         if (ack_ok)  bf_nxt = 1'b0;
         if (cpu_wr)  bf_nxt = 1'b1;
      end

      acc_nxt = accepted;
      if (edges.rise)        acc_nxt = 1'b0;
      if (load_in || ack_ok) acc_nxt = 1'b1;

      intr_nxt = intr;
      if (edges.rise && accepted && int_en) intr_nxt = 1'b1;
      if ((dir == DIR_IN && cpu_rd) || (dir == DIR_OUT && cpu_wr))
         intr_nxt = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         buf_full <= 1'b0;
         accepted <= 1'b0;
         intr     <= 1'b0;
      end else begin
         buf_full <= bf_nxt;
         accepted <= acc_nxt;
         intr     <= intr_nxt;
      end
   end

   // R4
   rd_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dir == DIR_IN && cpu_rd && buf_full) |=> (!buf_full && !intr));
   // R5
   intr_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(intr) |-> $past(int_en));
   // R6
   wr_sets_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dir == DIR_OUT && cpu_wr) |=> buf_full);
   // R7
   ack_releases_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dir == DIR_OUT && edges.fall && buf_full && !cpu_wr) |=> !buf_full);
   // R8
   wr_clears_intr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dir == DIR_OUT && cpu_wr) |=> !intr);
endmodule

// File: rtl/hsp_port_unit.sv
module hsp_port_unit
   import hsp_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dir_out,
   input  logic              int_en,
   input  logic              cpu_wr,
   input  logic [DATA_W-1:0] cpu_wdata,
   input  logic              cpu_rd,
   output logic [DATA_W-1:0] cpu_rdata,
   input  logic [DATA_W-1:0] per_din,
   output logic [DATA_W-1:0] per_dout,
   input  logic              stb_n,
   output logic              buf_full,
   output logic              intr
);
   initial begin
      if (DATA_W < 1)      $error("hsp_port_unit: DATA_W must be positive");
      if (SYNC_STAGES < 2) $error("hsp_port_unit: SYNC_STAGES must be >= 2");
   end

   logic      stb_s;
   hsp_edge_t edges;
   logic      load_in, load_out;
   hsp_dir_e  dir;

   assign dir = dir_out ? DIR_OUT : DIR_IN;

   hsp_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(STB_IDLE)) u_sync (
      .clk(clk), .rst_n(rst_n), .d_async(stb_n), .q_sync(stb_s));

   hsp_edge u_edge (.clk(clk), .rst_n(rst_n), .lvl(stb_s), .edges(edges));

   hsp_ctrl u_ctrl (
      .clk(clk), .rst_n(rst_n), .dir(dir), .int_en(int_en),
      .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .edges(edges),
      .load_in(load_in), .load_out(load_out),
      .buf_full(buf_full), .intr(intr));

   hsp_datareg #(.DATA_W(DATA_W)) u_in_reg (
      .clk(clk), .rst_n(rst_n), .load(load_in), .d(per_din), .q(cpu_rdata));

   hsp_datareg #(.DATA_W(DATA_W)) u_out_reg (
      .clk(clk), .rst_n(rst_n), .load(load_out), .d(cpu_wdata), .q(per_dout));

   // R3
   held_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!dir_out && buf_full && !cpu_rd) |=> $stable(cpu_rdata));
   // R10
   out_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!dir_out) |=> $stable(per_dout));
endmodule

// File: tb/hsp_port_unit_bench.sv
module hsp_port_unit_bench;
   localparam int W = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic dir_out = 1'b0, int_en = 1'b0, cpu_wr = 1'b0, cpu_rd = 1'b0;
   logic [W-1:0] cpu_wdata = '0, per_din = '0;
   logic stb_n = 1'b1;
   logic [W-1:0] cpu_rdata, per_dout;
   logic buf_full, intr;

   int n_chk = 0, n_fail = 0;

   always #2.5 clk = ~clk;

   hsp_port_unit u_hsp_port_unit (
      .clk(clk), .rst_n(rst_n), .dir_out(dir_out), .int_en(int_en),
      .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata), .cpu_rd(cpu_rd),
      .cpu_rdata(cpu_rdata), .per_din(per_din), .per_dout(per_dout),
      .stb_n(stb_n), .buf_full(buf_full), .intr(intr));

   task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic strobe_low(input logic [W-1:0] d);
      per_din = d; stb_n = 1'b0; idle(5);
   endtask

   task automatic strobe_high();
      stb_n = 1'b1; idle(5);
   endtask

   task automatic pulse_rd();
      cpu_rd = 1'b1; idle(1); cpu_rd = 1'b0; idle(1);
   endtask

   task automatic pulse_wr(input logic [W-1:0] d);
      cpu_wdata = d; cpu_wr = 1'b1; idle(1); cpu_wr = 1'b0; idle(1);
   endtask

   task automatic t_reset();
      chk("R1 buf_full", {7'd0, buf_full}, 8'h00);
      chk("R1 intr", {7'd0, intr}, 8'h00);
      chk("R1 per_dout", per_dout, 8'h00);
      chk("R1 cpu_rdata", cpu_rdata, 8'h00);
   endtask

   task automatic t_input_patterns();
      logic [W-1:0] pats [3] = '{8'hA5, 8'h00, 8'hFF};
      dir_out = 1'b0; int_en = 1'b0;
      foreach (pats[i]) begin
         strobe_low(pats[i]);
         per_din = ~pats[i];
         strobe_high();
         chk("R2 data", cpu_rdata, pats[i]);
         chk("R2 buf_full", {7'd0, buf_full}, 8'h01);
         chk("R5 no intr when disabled", {7'd0, intr}, 8'h00);
         pulse_rd();
         chk("R4 read clears buf_full", {7'd0, buf_full}, 8'h00);
      end
   endtask

   task automatic t_input_intr();
      dir_out = 1'b0; int_en = 1'b1;
      strobe_low(8'h3C);
      chk("R9 no intr while low", {7'd0, intr}, 8'h00);
      chk("R2 full while low", {7'd0, buf_full}, 8'h01);
      strobe_high();
      chk("R5 intr on rise", {7'd0, intr}, 8'h01);
      pulse_rd();
      chk("R4 read clears intr", {7'd0, intr}, 8'h00);
      chk("R4 read clears full", {7'd0, buf_full}, 8'h00);
   endtask

   task automatic t_overrun();
      dir_out = 1'b0; int_en = 1'b0;
      strobe_low(8'h5E); strobe_high();
      int_en = 1'b1;
      strobe_low(8'hC3); strobe_high();
      chk("R3 held byte kept", cpu_rdata, 8'h5E);
      chk("R3 ignored strobe no intr", {7'd0, intr}, 8'h00);
      chk("R3 still full", {7'd0, buf_full}, 8'h01);
      pulse_rd();
   endtask

   task automatic t_output();
      dir_out = 1'b1; int_en = 1'b1;
      pulse_wr(8'h5A);
      chk("R6 per_dout", per_dout, 8'h5A);
      chk("R6 buf_full", {7'd0, buf_full}, 8'h01);
      pulse_rd();
      chk("R10 rd ignored in output", {7'd0, buf_full}, 8'h01);
      stb_n = 1'b0; idle(5);
      chk("R7 ack clears full", {7'd0, buf_full}, 8'h00);
      chk("R9 no intr during ack", {7'd0, intr}, 8'h00);
      strobe_high();
      chk("R7 intr after ack", {7'd0, intr}, 8'h01);
      pulse_wr(8'h66);
      chk("R8 write clears intr", {7'd0, intr}, 8'h00);
      chk("R6 second write full", {7'd0, buf_full}, 8'h01);
      chk("R6 second data", per_dout, 8'h66);
      int_en = 1'b0;
      stb_n = 1'b0; idle(5); strobe_high();
      chk("R5 no intr when disabled (out)", {7'd0, intr}, 8'h00);
      chk("R7 released", {7'd0, buf_full}, 8'h00);
   endtask

   task automatic t_input_ignores_wr();
      dir_out = 1'b0;
      pulse_wr(8'h99);
      chk("R10 wr ignored in input", per_dout, 8'h66);
      chk("R10 no full from wr", {7'd0, buf_full}, 8'h00);
   endtask

   initial begin
      idle(3);
      t_reset();
      rst_n = 1'b1;
      idle(3);
      t_input_patterns();
      t_input_intr();
      t_overrun();
      t_output();
      t_input_ignores_wr();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule